// File: doc/BRIEF.md
# Carry-Skip Binary Adder

This block adds two unsigned WIDTH-bit operands and a single carry-in with no clock, producing a WIDTH-bit sum and a carry-out. The operand bits are split into WIDTH/GRP groups of GRP consecutive bits, least significant group first. Within a group the carry moves one bit at a time through generate/propagate cells.

Each group also ANDs together its propagate bits. When that product is 1, every bit of the group would pass its incoming carry straight through. In that case a multiplexer sends the group's carry-in directly to the next group and does not wait for the ripple. A long carry chain therefore crosses a run of fully propagating groups in one multiplexer step per group, instead of GRP ripple steps per group.

The adder is meant to sit in a wider datapath that needs a cheap adder of medium speed. The designer sets the total width and the group width as parameters.

Top module: `carry_skip_adder`

## Requirements
- R1: For all operands, {cout, sum} equals a + b + cin taken as an unsigned (WIDTH+1)-bit result; sum holds the low WIDTH bits and cout holds bit WIDTH.
- R2: Bit i generates a carry when a[i] AND b[i] is 1 and propagates one when a[i] XOR b[i] is 1. The carry-in acts as the carry into bit 0, and sum[i] is the propagate of bit i XOR the carry into bit i.
- R3: When all GRP propagate bits of a group are 1, the group's carry-out is its carry-in, and this agrees with the carry rippled through the group.
- R4: A group in which some bit generates is never bypassed, so its carry-out comes from the ripple (for example, a = 16'h8000, b = 16'h8000, cin = 0 gives sum 0 and cout 1).
- R5: A group whose bits all have a[i] = b[i] = 0 stops any incoming carry, giving a group carry-out of 0 (for example, a = 16'h0FFF, b = 0, cin = 1 gives sum 16'h1000 and cout 0).
- R6: A carry-in can travel through every group by bypass: a = all ones, b = 0, cin = 1 gives sum 0 and cout 1. Alternating patterns with a XOR b all ones behave the same way.
- R7: WIDTH must be a positive multiple of GRP, and elaboration stops otherwise. Any legal pair, for example WIDTH = 6 with GRP = 3, meets R1 for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a    | input     | WIDTH | First addend |
| b    | input     | WIDTH | Second addend |
| cin  | input     | 1     | Carry into bit 0 |
| sum  | output    | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output    | 1     | Carry out of the top bit |

## Verification
The hardest case to bring about from the ports is a carry that enters a group whose bits all propagate, so that the bypass multiplexer alone decides the next group's carry. Random operands almost never make four bits propagate at once across several groups. The stimulus therefore sets up this case directly: all-ones against zero, alternating complementary patterns, and operands built so that one chosen group propagates while the groups below it generate or kill. A small configuration is also run exhaustively, which reaches every propagate pattern of every group with both carry-in values.

// File: rtl/csa_pkg.sv
package csa_pkg;

  function automatic logic gen_bit(input logic x, input logic y);
    return x & y;
  endfunction

  function automatic logic prop_bit(input logic x, input logic y);
    return x ^ y;
  endfunction

  // one AND-OR stage: carry out of a cell given its generate, propagate and carry in
  function automatic logic and_or(input logic g, input logic p, input logic c);
    return g | (p & c);
  endfunction

endpackage

// File: rtl/csa_pg.sv
module csa_pg #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] g,
  output logic [W-1:0] p
);
  import csa_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign g[i] = gen_bit(a[i], b[i]);
    assign p[i] = prop_bit(a[i], b[i]);
  end

  // R2: a bit never both generates and propagates
  always_comb begin
    a_r2_pg_exclusive: assert ((g & p) == '0)
      else $error("bit generates and propagates at once");
  end

endmodule

// File: rtl/csa_group.sv
module csa_group #(
  parameter int GRP = 4
) (
  input  logic [GRP-1:0] g,
  input  logic [GRP-1:0] p,
  input  logic           cin,
  output logic [GRP-1:0] cin_bits,
  output logic           cout,
  output logic           skip
);
  import csa_pkg::*;

  logic rip;

  always_comb begin
    logic c;
    c = cin;
    for (int i = 0; i < GRP; i++) begin
      cin_bits[i] = c;
      c = and_or(g[i], p[i], c);
    end
    rip  = c;
    skip = &p;
    cout = skip ? cin : rip;
  end

  always_comb begin
    // R3: the bypass path and the ripple path agree whenever the bypass is taken
    if (skip) begin
      a_r3_skip_matches_ripple: assert (rip == cin)
        else $error("bypass carry differs from rippled carry");
    end
    // R4: a generating bit rules out the bypass
    if (|g) begin
      a_r4_gen_blocks_skip: assert (!skip)
        else $error("group with a generating bit selected bypass");
    end
    // R5: a group of killing bits emits no carry
    if ((g | p) == '0) begin
      a_r5_kill_stops_carry: assert (cout == 1'b0)
        else $error("killed group produced a carry");
    end
  end

endmodule

// File: rtl/csa_sum.sv
module csa_sum #(
  parameter int W = 16
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] c,
  output logic [W-1:0] s
);
  assign s = p ^ c;
endmodule

// File: rtl/carry_skip_adder.sv
module carry_skip_adder #(
  parameter int WIDTH = 16,
  parameter int GRP   = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NGRP = (GRP > 0) ? WIDTH / GRP : 1;

  // R7: width must split into whole groups
  if (GRP < 1 || (WIDTH % GRP) != 0) begin : g_bad_split
    $error("WIDTH must be a positive multiple of GRP");
  end

  logic [WIDTH-1:0] g_vec;
  logic [WIDTH-1:0] p_vec;
  logic [WIDTH-1:0] bit_carry;
  logic [NGRP:0]    grp_carry;
  logic [NGRP-1:0]  grp_skip;

  csa_pg #(.W(WIDTH)) u_pg (
    .a (a),
    .b (b),
    .g (g_vec),
    .p (p_vec)
  );

  assign grp_carry[0] = cin;

  for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
    csa_group #(.GRP(GRP)) u_grp (
      .g        (g_vec[gi*GRP +: GRP]),
      .p        (p_vec[gi*GRP +: GRP]),
      .cin      (grp_carry[gi]),
      .cin_bits (bit_carry[gi*GRP +: GRP]),
      .cout     (grp_carry[gi+1]),
      .skip     (grp_skip[gi])
    );
  end

  csa_sum #(.W(WIDTH)) u_sum (
    .p (p_vec),
    .c (bit_carry),
    .s (sum)
  );

  assign cout = grp_carry[NGRP];

  // R1: the structural result equals plain addition
  always_comb begin
    a_r1_matches_add: assert ({cout, sum} ==
        ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
      else $error("structural sum differs from arithmetic sum");
    // R6: a fully propagating operand pair hands carry-in to carry-out
    if (&grp_skip) begin
      a_r6_full_bypass: assert (cout == cin)
        else $error("all groups bypass but cout differs from cin");
    end
  end

endmodule

// File: tb/carry_skip_adder_test.sv
module carry_skip_adder_test;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int WS = 6;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [W-1:0]  a, b, sum;
  logic          cin, cout;
  logic [WS-1:0] as, bs, sums;
  logic          cins, couts;

  carry_skip_adder #(.WIDTH(W), .GRP(4)) uut (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  carry_skip_adder #(.WIDTH(WS), .GRP(3)) uut_small (
    .a(as), .b(bs), .cin(cins), .sum(sums), .cout(couts)
  );

  // bench model: full-adder truth per bit, written independently of the RTL
  function automatic logic [W:0] ref16(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    logic [W:0] r;
    logic k;
    k = c;
    for (int i = 0; i < W; i++) begin
      r[i] = (x[i] + y[i] + k) % 2;
      k    = ((x[i] + y[i] + k) >= 2);
    end
    r[W] = k;
    return r;
  endfunction

  function automatic logic [WS:0] ref6(input logic [WS-1:0] x, input logic [WS-1:0] y, input logic c);
    int t;
    t = int'(x) + int'(y) + int'(c);
    return t[WS:0];
  endfunction

  task automatic check16(input logic [W-1:0] x, input logic [W-1:0] y, input logic c, input string req);
    logic [W:0] exp;
    a = x; b = y; cin = c;
    #(CLK_PERIOD);
    exp = ref16(x, y, c);
    total++;
    if ({cout, sum} !== exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, x, y, c, {cout, sum}, exp);
    end
  endtask

  task automatic check6(input logic [WS-1:0] x, input logic [WS-1:0] y, input logic c);
    logic [WS:0] exp;
    as = x; bs = y; cins = c;
    #1;
    exp = ref6(x, y, c);
    total++;
    if ({couts, sums} !== exp) begin
      bad++;
      $display("FAIL R7 a=%h b=%h cin=%b actual=%h expected=%h", x, y, c, {couts, sums}, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    as = '0; bs = '0; cins = 1'b0;
    void'($urandom(32'd20231));
    #(CLK_PERIOD/2);

    // R1: zero inputs give zero result
    check16(16'h0000, 16'h0000, 1'b0, "R1");
    check16(16'h1234, 16'h4321, 1'b0, "R1");
    check16(16'hFFFF, 16'hFFFF, 1'b1, "R1");
    // R2: carry-in is the carry into bit 0
    check16(16'h0000, 16'h0000, 1'b1, "R2");
    check16(16'h0001, 16'h0001, 1'b0, "R2");
    // R4: generating top bit
    check16(16'h8000, 16'h8000, 1'b0, "R4");
    check16(16'h00F0, 16'h0010, 1'b0, "R4");
    // R5: killing group stops the carry
    check16(16'h0FFF, 16'h0000, 1'b1, "R5");
    check16(16'hF0FF, 16'h0000, 1'b1, "R5");
    // R6: full bypass chain
    check16(16'hFFFF, 16'h0000, 1'b1, "R6");
    check16(16'h0000, 16'hFFFF, 1'b1, "R6");
    check16(16'hAAAA, 16'h5555, 1'b1, "R6");
    check16(16'hAAAA, 16'h5555, 1'b0, "R6");
    // R3: one propagating group fed by a generate below it
    for (int gsel = 1; gsel < 4; gsel++) begin
      logic [W-1:0] x, y;
      x = 16'hFFFF >> (16 - 4*gsel);
      x = x | (16'h000F << (4*gsel));
      y = 16'h0001;
      check16(x, y, 1'b0, "R3");
      check16(16'h000F << (4*gsel), 16'h0000, 1'b1, "R3");
    end
    // R1: random operands, some forced to long propagate runs
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] x, y;
      x = W'($urandom);
      y = W'($urandom);
      if (n % 4 == 0) y = ~x ^ W'(1 << (n % W));
      check16(x, y, 1'(n % 2), "R1");
    end
    // R7: exhaustive on the 6-bit, 3-bit-group configuration
    for (int x = 0; x < 64; x++)
      for (int y = 0; y < 64; y++)
        for (int c = 0; c < 2; c++)
          check6(WS'(x), WS'(y), 1'(c));

    done = 1'b1;
    summary();
    $finish;
  end

endmodule